// File: doc/BRIEF.md
# UART Receive Character Buffer

This block is the receive-side buffering stage of one UART channel. It sits between the receiver that assembles serial characters and the CPU register interface. Each character arrives with its data and three error flags (parity, framing, break). The block queues it in a three-slot first-in first-out store. When the store is full, one more character can wait in a holding stage that stands for the receive shift register. Up to four characters are therefore buffered before any data is lost.

The CPU sees the head entry and a set of flags: ready, full and a sticky overrun flag. The error flags it sees depend on the error mode. In per-character mode they belong to the head entry only. In block mode they are an accumulated OR, which a clear-error command resets. The block also drives an interrupt request (from ready or full), a DMA request (from receive-ready or an external transmit-ready), and an optional automatic RTS output for flow control.

Top module: `uart_rxbuf`

## Requirements
- R1: Up to three characters are queued and a fourth waits in the holding stage. All four are returned by successive reads in arrival order, with no loss.
- R2: Each queued entry keeps its data byte together with its own parity, framing and break flags. On the ports these flags are `err_par_o`, `err_frm_o` and `err_brk_o`. Overrun is never stored per entry.
- R3: `ready_o` is 1 exactly when at least one entry is queued. `full_o` is 1 exactly when all three slots are occupied.
- R4: A one-cycle `rd_strobe_i` removes the head entry, and the next entry becomes the head after that clock edge. A strobe on an empty queue is ignored. Idle cycles without a strobe never change the head.
- R5: A character completed while the queue is full is kept in the holding stage. It moves into the queue in the same cycle that a slot is freed.
- R6: A `start_det_i` pulse sets `ovr_o` from the next cycle, but only if a held character is present and no slot is freed in that cycle. A start bit while the holding stage is empty never sets it. A character completed while the holding stage is occupied replaces the held one, and the queued entries are unchanged.
- R7: With `cfg_blk_mode_i`=0, the error outputs show the head entry's flags, and 0 when the queue is empty.
- R8: With `cfg_blk_mode_i`=1, the error outputs show the OR of the flags of every entry that has become head since the last `clr_err_i`. `clr_err_i` clears this OR; an entry that becomes head in the same cycle is still included.
- R9: `irq_o` follows `full_o` when `cfg_irq_full_i`=1 and `ready_o` otherwise. `dma_req_o` follows `tx_ready_i` when `cfg_dma_tx_i`=1 and `ready_o` otherwise.
- R10: With `cfg_auto_rts_i`=1, `rts_o` goes to 0 one cycle after `start_det_i` while the queue is full. It returns to 1 one cycle after the queue is no longer full. With `cfg_auto_rts_i`=0, `rts_o` stays 1.
- R11: `ovr_o` stays set until `clr_err_i` or a synchronous reset. The reset empties the queue and the holding stage, clears all flags and sets `rts_o` to 1.
- R12: A read and a character completion in the same cycle while the queue is full both take effect. The queue stays full, and the entries read afterwards are the remaining old ones followed by the new one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| srst_i | input | 1 | Synchronous reset, active high |
| chr_valid_i | input | 1 | One-cycle pulse: an assembled character is complete |
| chr_data_i | input | DATA_W | Data of the completed character |
| chr_par_i | input | 1 | Parity error of the completed character |
| chr_frm_i | input | 1 | Framing error of the completed character |
| chr_brk_i | input | 1 | Break received with the completed character |
| start_det_i | input | 1 | One-cycle pulse: a valid start bit was detected |
| rd_strobe_i | input | 1 | CPU read of the receive buffer (pops the head) |
| clr_err_i | input | 1 | Reset-error-status command |
| cfg_blk_mode_i | input | 1 | 1 = block error mode, 0 = per-character mode |
| cfg_irq_full_i | input | 1 | 1 = interrupt from full, 0 = from ready |
| cfg_dma_tx_i | input | 1 | 1 = DMA request from tx_ready_i, 0 = from ready |
| cfg_auto_rts_i | input | 1 | Enables automatic RTS control |
| tx_ready_i | input | 1 | Transmitter ready, a candidate DMA source |
| head_data_o | output | DATA_W | Data of the head entry |
| err_par_o | output | 1 | Reported parity error |
| err_frm_o | output | 1 | Reported framing error |
| err_brk_o | output | 1 | Reported received break |
| ready_o | output | 1 | At least one character queued |
| full_o | output | 1 | All queue slots occupied |
| ovr_o | output | 1 | Sticky overrun flag |
| irq_o | output | 1 | Interrupt request |
| dma_req_o | output | 1 | DMA request |
| rts_o | output | 1 | RTS output, 1 = asserted |

## Verification
The queue is exercised with several arrival patterns:
- Single characters with idle gaps, which show that the head is stable and that a read on an empty queue is ignored.
- A burst of four, which separates the holding stage from the queue slots.
- A burst of five with a start bit in between, which separates a true overrun from a start bit that arrives while only the queue is full.
- A read and a completion in the same cycle on a full queue, which exposes lost or duplicated entries.

The same arrival sequence, with different error flags on each character, is also read in both error modes. This tells head-only reporting apart from accumulated reporting and shows the effect of the clear-error command.

// File: rtl/rxb_pkg.sv
package rxb_pkg;
   // per-character error flags carried with every queued entry
   typedef struct packed {
      logic brk;
      logic frm;
      logic par;
   } rxb_flags_t;

   localparam int unsigned RXB_FLAG_W = $bits(rxb_flags_t);
endpackage

// File: rtl/rxb_hold.sv
module rxb_hold
   import rxb_pkg::*;
#(
   parameter int unsigned DATA_W = 8
) (
   input  logic              clk_i,
   input  logic              srst_i,
   input  logic              chr_valid_i,
   input  logic [DATA_W-1:0] chr_data_i,
   input  rxb_flags_t        chr_flags_i,
   input  logic              room_i,
   input  logic              start_det_i,
   output logic              push_o,
   output logic [DATA_W-1:0] push_data_o,
   output rxb_flags_t        push_flags_o,
   output logic              hold_valid_o,
   output logic              ovr_set_o
);
   logic              hv_q;
   logic [DATA_W-1:0] hd_q;
   rxb_flags_t        hf_q;

   // the held character has priority over a freshly completed one
   assign push_o       = room_i && (hv_q || chr_valid_i);
   assign push_data_o  = hv_q ? hd_q : chr_data_i;
   assign push_flags_o = hv_q ? hf_q : chr_flags_i;
   assign hold_valid_o = hv_q;
   assign ovr_set_o    = start_det_i && hv_q && !room_i;

   always_ff @(posedge clk_i) begin
      if (srst_i) begin
         hv_q <= 1'b0;
         hd_q <= '0;
         hf_q <= '0;
      end else if (chr_valid_i && (hv_q || !room_i)) begin
         // new character lands in the holding stage (old one, if any, is lost)
         hv_q <= 1'b1;
         hd_q <= chr_data_i;
         hf_q <= chr_flags_i;
      end else if (room_i) begin
         hv_q <= 1'b0;
      end
   end

   AST_HOLD_DRAINS: assert property (@(posedge clk_i) disable iff (srst_i)
      hv_q && room_i && !chr_valid_i |=> !hv_q);  // R5
endmodule

// File: rtl/rxb_queue.sv
module rxb_queue
   import rxb_pkg::*;
#(
   parameter  int unsigned DATA_W = 8,
   parameter  int unsigned DEPTH  = 3,
   localparam int unsigned PTR_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int unsigned CNT_W  = $clog2(DEPTH + 1)
) (
   input  logic              clk_i,
   input  logic              srst_i,
   input  logic              push_i,
   input  logic [DATA_W-1:0] push_data_i,
   input  rxb_flags_t        push_flags_i,
   input  logic              pop_i,
   output logic [DATA_W-1:0] head_data_o,
   output rxb_flags_t        head_flags_o,
   output logic              arrive_o,
   output rxb_flags_t        arrive_flags_o,
   output logic [CNT_W-1:0]  count_o
);
   logic [DATA_W-1:0] dat_q [DEPTH];
   rxb_flags_t        flg_q [DEPTH];
   logic [PTR_W-1:0]  rp_q, wp_q, rp_inc, wp_inc;
   logic [CNT_W-1:0]  cnt_q;
   logic              deep;

   // pointer wrap: free-running for power-of-two depths, compare otherwise
   if ((DEPTH & (DEPTH - 1)) == 0) begin : g_pow2
      assign rp_inc = rp_q + 1'b1;
      assign wp_inc = wp_q + 1'b1;
   end else begin : g_wrap
      assign rp_inc = (rp_q == PTR_W'(DEPTH - 1)) ? '0 : rp_q + 1'b1;
      assign wp_inc = (wp_q == PTR_W'(DEPTH - 1)) ? '0 : wp_q + 1'b1;
   end

   assign head_data_o  = dat_q[rp_q];
   assign head_flags_o = (cnt_q != '0) ? flg_q[rp_q] : '0;
   assign count_o      = cnt_q;
   assign deep         = cnt_q >= CNT_W'(2);

   // an entry reaches the head either by shifting up or by entering empty
   assign arrive_o = (pop_i && deep) ||
                     (push_i && ((cnt_q == '0) || (cnt_q == CNT_W'(1) && pop_i)));
   assign arrive_flags_o = (pop_i && deep) ? flg_q[rp_inc] : push_flags_i;

   always_ff @(posedge clk_i) begin
      if (push_i) begin
         dat_q[wp_q] <= push_data_i;
         flg_q[wp_q] <= push_flags_i;
      end
   end

   always_ff @(posedge clk_i) begin
      if (srst_i) begin
         rp_q  <= '0;
         wp_q  <= '0;
         cnt_q <= '0;
      end else begin
         if (push_i) wp_q <= wp_inc;
         if (pop_i)  rp_q <= rp_inc;
         cnt_q <= cnt_q + CNT_W'(push_i) - CNT_W'(pop_i);
      end
   end

   AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (srst_i)
      push_i |-> (cnt_q != CNT_W'(DEPTH)) || pop_i);  // R5
   AST_NO_UNDERFLOW: assert property (@(posedge clk_i) disable iff (srst_i)
      pop_i |-> cnt_q != '0);  // R4
   AST_POP_DECREMENTS: assert property (@(posedge clk_i) disable iff (srst_i)
      pop_i && !push_i |=> cnt_q == $past(cnt_q) - CNT_W'(1));  // R4
   AST_COUNT_BOUND: assert property (@(posedge clk_i) disable iff (srst_i)
      cnt_q <= CNT_W'(DEPTH));  // R1
endmodule

// File: rtl/rxb_status.sv
module rxb_status
   import rxb_pkg::*;
(
   input  logic       clk_i,
   input  logic       srst_i,
   input  logic       blk_mode_i,
   input  logic       clr_i,
   input  logic       arrive_i,
   input  rxb_flags_t arrive_flags_i,
   input  rxb_flags_t head_flags_i,
   input  logic       ovr_set_i,
   output rxb_flags_t rep_flags_o,
   output logic       ovr_o
);
   rxb_flags_t acc_q;
   logic       ovr_q;

   always_ff @(posedge clk_i) begin
      if (srst_i) begin
         acc_q <= '0;
         ovr_q <= 1'b0;
      end else begin
         acc_q <= (clr_i ? rxb_flags_t'('0) : acc_q) |
                  (arrive_i ? arrive_flags_i : rxb_flags_t'('0));
         ovr_q <= ovr_set_i || (ovr_q && !clr_i);
      end
   end

   assign rep_flags_o = blk_mode_i ? acc_q : head_flags_i;
   assign ovr_o       = ovr_q;

   AST_OVR_STICKY: assert property (@(posedge clk_i) disable iff (srst_i)
      ovr_q && !clr_i |=> ovr_q);  // R11
   AST_ACC_CLEARED: assert property (@(posedge clk_i) disable iff (srst_i)
      clr_i && !arrive_i |=> acc_q == '0);  // R8
   AST_ACC_KEEPS: assert property (@(posedge clk_i) disable iff (srst_i)
      !clr_i |=> (acc_q & $past(acc_q)) == $past(acc_q));  // R8
endmodule

// File: rtl/rxb_flow.sv
module rxb_flow (
   input  logic clk_i,
   input  logic srst_i,
   input  logic ready_i,
   input  logic full_i,
   input  logic start_det_i,
   input  logic tx_ready_i,
   input  logic cfg_irq_full_i,
   input  logic cfg_dma_tx_i,
   input  logic cfg_auto_rts_i,
   output logic irq_o,
   output logic dma_req_o,
   output logic rts_o
);
   logic rts_q;

   always_ff @(posedge clk_i) begin
      if (srst_i || !cfg_auto_rts_i) rts_q <= 1'b1;
      else if (start_det_i && full_i) rts_q <= 1'b0;
      else if (!full_i)               rts_q <= 1'b1;
   end

   assign irq_o     = cfg_irq_full_i ? full_i : ready_i;
   assign dma_req_o = cfg_dma_tx_i ? tx_ready_i : ready_i;
   assign rts_o     = rts_q;

   AST_RTS_NEGATE: assert property (@(posedge clk_i) disable iff (srst_i)
      cfg_auto_rts_i && start_det_i && full_i |=> !rts_o);  // R10
   AST_RTS_RESTORE: assert property (@(posedge clk_i) disable iff (srst_i)
      !full_i |=> rts_o);  // R10
endmodule

// File: rtl/uart_rxbuf.sv
module uart_rxbuf
   import rxb_pkg::*;
#(
   parameter int unsigned DATA_W = 8,
   parameter int unsigned DEPTH  = 3
) (
   input  logic              clk_i,
   input  logic              srst_i,
   input  logic              chr_valid_i,
   input  logic [DATA_W-1:0] chr_data_i,
   input  logic              chr_par_i,
   input  logic              chr_frm_i,
   input  logic              chr_brk_i,
   input  logic              start_det_i,
   input  logic              rd_strobe_i,
   input  logic              clr_err_i,
   input  logic              cfg_blk_mode_i,
   input  logic              cfg_irq_full_i,
   input  logic              cfg_dma_tx_i,
   input  logic              cfg_auto_rts_i,
   input  logic              tx_ready_i,
   output logic [DATA_W-1:0] head_data_o,
   output logic              err_par_o,
   output logic              err_frm_o,
   output logic              err_brk_o,
   output logic              ready_o,
   output logic              full_o,
   output logic              ovr_o,
   output logic              irq_o,
   output logic              dma_req_o,
   output logic              rts_o
);
   localparam int unsigned CNT_W = $clog2(DEPTH + 1);

   if (DATA_W < 5 || DATA_W > 9) begin : g_bad_width
      $error("uart_rxbuf: DATA_W must lie between 5 and 9");
   end
   if (DEPTH < 2) begin : g_bad_depth
      $error("uart_rxbuf: DEPTH must be at least 2");
   end

   rxb_flags_t        chr_flags, push_flags, head_flags, arrive_flags, rep_flags;
   logic [DATA_W-1:0] push_data;
   logic [CNT_W-1:0]  count;
   logic              push, pop, room, hold_valid, ovr_set, arrive;

   assign chr_flags = '{brk: chr_brk_i, frm: chr_frm_i, par: chr_par_i};
   assign ready_o   = count != '0;
   assign full_o    = count == CNT_W'(DEPTH);
   assign pop       = rd_strobe_i && ready_o;
   assign room      = !full_o || pop;

   rxb_hold #(.DATA_W(DATA_W)) hold_i (
      .clk_i        (clk_i),
      .srst_i       (srst_i),
      .chr_valid_i  (chr_valid_i),
      .chr_data_i   (chr_data_i),
      .chr_flags_i  (chr_flags),
      .room_i       (room),
      .start_det_i  (start_det_i),
      .push_o       (push),
      .push_data_o  (push_data),
      .push_flags_o (push_flags),
      .hold_valid_o (hold_valid),
      .ovr_set_o    (ovr_set)
   );

   rxb_queue #(.DATA_W(DATA_W), .DEPTH(DEPTH)) queue_i (
      .clk_i          (clk_i),
      .srst_i         (srst_i),
      .push_i         (push),
      .push_data_i    (push_data),
      .push_flags_i   (push_flags),
      .pop_i          (pop),
      .head_data_o    (head_data_o),
      .head_flags_o   (head_flags),
      .arrive_o       (arrive),
      .arrive_flags_o (arrive_flags),
      .count_o        (count)
   );

   rxb_status status_i (
      .clk_i          (clk_i),
      .srst_i         (srst_i),
      .blk_mode_i     (cfg_blk_mode_i),
      .clr_i          (clr_err_i),
      .arrive_i       (arrive),
      .arrive_flags_i (arrive_flags),
      .head_flags_i   (head_flags),
      .ovr_set_i      (ovr_set),
      .rep_flags_o    (rep_flags),
      .ovr_o          (ovr_o)
   );

   rxb_flow flow_i (
      .clk_i          (clk_i),
      .srst_i         (srst_i),
      .ready_i        (ready_o),
      .full_i         (full_o),
      .start_det_i    (start_det_i),
      .tx_ready_i     (tx_ready_i),
      .cfg_irq_full_i (cfg_irq_full_i),
      .cfg_dma_tx_i   (cfg_dma_tx_i),
      .cfg_auto_rts_i (cfg_auto_rts_i),
      .irq_o          (irq_o),
      .dma_req_o      (dma_req_o),
      .rts_o          (rts_o)
   );

   assign err_par_o = rep_flags.par;
   assign err_frm_o = rep_flags.frm;
   assign err_brk_o = rep_flags.brk;

   AST_HOLD_NEEDS_FULL: assert property (@(posedge clk_i) disable iff (srst_i)
      hold_valid |-> full_o);  // R5
   AST_SAME_CYCLE_RD_PUSH: assert property (@(posedge clk_i) disable iff (srst_i)
      full_o && pop && push |=> full_o);  // R12
   AST_OVR_NEEDS_HOLD: assert property (@(posedge clk_i) disable iff (srst_i)
      !ovr_o ##1 ovr_o |-> $past(hold_valid));  // R6
endmodule

// File: tb/uart_rxbuf_tb_top.sv
module uart_rxbuf_tb_top;
   localparam int CLK_PERIOD = 10;

   typedef struct packed {
      logic [7:0] d;
      logic [2:0] f;  // {brk, frm, par}
   } item_t;

   logic clk = 1'b0;
   logic srst = 1'b1;
   logic chr_valid = 0, par = 0, frm = 0, brk = 0, start_det = 0, rd = 0, clr = 0;
   logic blk = 0, irq_full = 0, dma_tx = 0, auto_rts = 0, tx_ready = 0;
   logic [7:0] chr_data = '0;
   logic [7:0] head_data;
   logic e_par, e_frm, e_brk, ready, full, ovr, irq, dma_req, rts;

   int checks = 0;
   int errors = 0;
   bit done = 0;
   item_t exp_q[$];
   item_t mh;
   bit mh_valid = 0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   uart_rxbuf dut_i (
      .clk_i(clk), .srst_i(srst), .chr_valid_i(chr_valid), .chr_data_i(chr_data),
      .chr_par_i(par), .chr_frm_i(frm), .chr_brk_i(brk), .start_det_i(start_det),
      .rd_strobe_i(rd), .clr_err_i(clr), .cfg_blk_mode_i(blk),
      .cfg_irq_full_i(irq_full), .cfg_dma_tx_i(dma_tx), .cfg_auto_rts_i(auto_rts),
      .tx_ready_i(tx_ready), .head_data_o(head_data), .err_par_o(e_par),
      .err_frm_o(e_frm), .err_brk_o(e_brk), .ready_o(ready), .full_o(full),
      .ovr_o(ovr), .irq_o(irq), .dma_req_o(dma_req), .rts_o(rts)
   );

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic step();
      @(negedge clk);
   endtask

   // driver: completes one character and updates the expected model
   task automatic send(logic [7:0] d, logic [2:0] f);
      chr_valid = 1; chr_data = d; {brk, frm, par} = f;
      step();
      chr_valid = 0;
      if (!mh_valid && exp_q.size() < 3) exp_q.push_back('{d: d, f: f});
      else begin mh = '{d: d, f: f}; mh_valid = 1; end
   endtask

   task automatic model_pop();
      void'(exp_q.pop_front());
      if (mh_valid) begin exp_q.push_back(mh); mh_valid = 0; end
   endtask

   // monitor: compares the head with the oldest expected item, then pops it
   task automatic read_chk(string req);
      item_t e;
      e = exp_q[0];
      check(req, {31'd0, ready}, 32'd1);
      check(req, {24'd0, head_data}, {24'd0, e.d});
      if (!blk) check("R7", {29'd0, e_brk, e_frm, e_par}, {29'd0, e.f});
      rd = 1; step(); rd = 0;
      model_pop();
   endtask

   task automatic pulse_start();
      start_det = 1; step(); start_det = 0;
   endtask

   task automatic pulse_clr();
      clr = 1; step(); clr = 0;
   endtask

   task automatic drain(string req);
      while (exp_q.size() > 0) read_chk(req);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog actual=timeout expected=finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) step();
      srst = 0;
      step();
      // reset state (R11, R3)
      check("R3 ready after reset", {31'd0, ready}, 0);
      check("R3 full after reset", {31'd0, full}, 0);
      check("R11 ovr after reset", {31'd0, ovr}, 0);
      check("R11 rts after reset", {31'd0, rts}, 1);

      // R1/R2/R3/R5/R7: burst of four with distinct flags
      send(8'h11, 3'b001);
      check("R3 ready one entry", {31'd0, ready}, 1);
      check("R3 not full one entry", {31'd0, full}, 0);
      send(8'h22, 3'b010);
      send(8'h33, 3'b100);
      check("R3 full three entries", {31'd0, full}, 1);
      send(8'h44, 3'b011);
      check("R5 full with held char", {31'd0, full}, 1);
      check("R2 head keeps flags", {29'd0, e_brk, e_frm, e_par}, 3'b001);
      read_chk("R1 order 1");
      check("R5 held moved in, still full", {31'd0, full}, 1);
      drain("R1 order rest");
      check("R3 empty after drain", {31'd0, ready}, 0);
      check("R7 flags zero when empty", {29'd0, e_brk, e_frm, e_par}, 0);

      // R4: read on empty ignored, idle keeps head
      rd = 1; step(); rd = 0;
      check("R4 empty read ignored", {31'd0, ready}, 0);
      send(8'h5a, 3'b000);
      repeat (5) step();
      check("R4 head stable when idle", {24'd0, head_data}, 32'h5a);
      read_chk("R4 single read");
      check("R4 read removes head", {31'd0, ready}, 0);

      // R6: overrun only with a held character
      send(8'h61, 3'b000); send(8'h62, 3'b000); send(8'h63, 3'b000);
      pulse_start();
      check("R6 no ovr without held char", {31'd0, ovr}, 0);
      send(8'h64, 3'b000);
      pulse_start();
      check("R6 ovr set on second start", {31'd0, ovr}, 1);
      send(8'h65, 3'b010);
      check("R6 queue untouched", {24'd0, head_data}, 32'h61);
      drain("R6 held replaced");
      check("R11 ovr sticky after reads", {31'd0, ovr}, 1);
      pulse_clr();
      check("R11 ovr cleared by command", {31'd0, ovr}, 0);

      // R12: read and push in the same cycle on a full queue
      send(8'h71, 3'b000); send(8'h72, 3'b000); send(8'h73, 3'b000);
      check("R12 head before", {24'd0, head_data}, 32'h71);
      rd = 1; chr_valid = 1; chr_data = 8'h74; {brk, frm, par} = 3'b100;
      step();
      rd = 0; chr_valid = 0;
      void'(exp_q.pop_front());
      exp_q.push_back('{d: 8'h74, f: 3'b100});
      check("R12 still full", {31'd0, full}, 1);
      drain("R12 no loss or duplicate");
      check("R12 empty at end", {31'd0, ready}, 0);

      // R10: automatic RTS
      auto_rts = 1;
      send(8'h81, 3'b000); send(8'h82, 3'b000); send(8'h83, 3'b000);
      check("R10 rts high while full, no start", {31'd0, rts}, 1);
      pulse_start();
      check("R10 rts negated", {31'd0, rts}, 0);
      read_chk("R10 read frees slot");
      step();
      check("R10 rts reasserted", {31'd0, rts}, 1);
      auto_rts = 0;
      send(8'h84, 3'b000);
      pulse_start();
      check("R10 rts stays high when disabled", {31'd0, rts}, 1);

      // R9: interrupt and DMA selection (queue full here)
      irq_full = 0; step();
      check("R9 irq from ready", {31'd0, irq}, 1);
      irq_full = 1; step();
      check("R9 irq from full", {31'd0, irq}, 1);
      read_chk("R9 read");
      check("R9 irq from full, not full", {31'd0, irq}, 0);
      dma_tx = 1; tx_ready = 0; step();
      check("R9 dma from tx ready", {31'd0, dma_req}, 0);
      dma_tx = 0; step();
      check("R9 dma from rx ready", {31'd0, dma_req}, 1);
      irq_full = 0;
      drain("R9 drain");

      // R8: block error mode
      blk = 1;
      pulse_clr();
      send(8'h91, 3'b001); send(8'h92, 3'b010); send(8'h93, 3'b000);
      check("R8 first head only", {29'd0, e_brk, e_frm, e_par}, 3'b001);
      read_chk("R8 read 1");
      check("R8 accumulated", {29'd0, e_brk, e_frm, e_par}, 3'b011);
      pulse_clr();
      check("R8 cleared", {29'd0, e_brk, e_frm, e_par}, 3'b000);
      read_chk("R8 read 2");
      check("R8 clean arrival", {29'd0, e_brk, e_frm, e_par}, 3'b000);
      read_chk("R8 read 3");
      send(8'h94, 3'b100);
      check("R8 new arrival", {29'd0, e_brk, e_frm, e_par}, 3'b100);
      drain("R8 drain");
      blk = 0;

      // R11: synchronous reset clears everything
      send(8'ha1, 3'b000); send(8'ha2, 3'b000); send(8'ha3, 3'b000);
      send(8'ha4, 3'b000);
      auto_rts = 1;
      pulse_start();
      check("R11 ovr before reset", {31'd0, ovr}, 1);
      srst = 1; step(); srst = 0;
      exp_q.delete(); mh_valid = 0;
      check("R11 queue emptied", {31'd0, ready}, 0);
      check("R11 ovr cleared", {31'd0, ovr}, 0);
      check("R11 rts asserted", {31'd0, rts}, 1);
      send(8'hb1, 3'b000);
      read_chk("R11 holding stage emptied");
      check("R11 nothing held", {31'd0, ready}, 0);

      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule